// File: doc/BRIEF.md
# Serial Channel Baud Clock Generator

This block sets the bit timing for one asynchronous serial channel. It holds a small control register that a processor writes and reads. From the system clock it derives two single-cycle enables: a sampling enable at the oversampled rate and a baud enable at the bit rate. A channel's shift and framing logic uses these enables. Three dividers run one after the other. A prescaler divides by 10 or by 30. A binary stage divides by a power of two. A final stage divides by 16 or by 64 to go from sampling rate to bit rate. One speed code skips the internal chain and takes the sampling rate from an external data clock.

The block also gives the parity sense to the parity logic. It gates the transmit-empty flag with the clear-to-send pin. When the processor reads the prescale bit, it sees the live clear-to-send pin and not the value it last wrote.

Top module: `baud_clkgen`

## Requirements
- R1: After reset, the control fields are: parity sense 0, ratio 0, prescale 0, speed code 111. A read returns `{2'b00, 3'b111, cts_in, 1'b0, 1'b0}`, and `parity_odd` is 0.
- R2: Read data bit 2 always equals the current level of `cts_in`, whatever was last written to that bit.
- R3: `tx_empty` is `txbuf_empty & ~cts_in`. While `cts_in` is high it is 0.
- R4: Write data bit 2 sets the prescale. A 0 divides the system clock by 10 and a 1 divides it by 30.
- R5: Speed codes 0 to 6 (write data bits 5:3) divide the prescaled rate by 2^code. So the sampling enable repeats every prescale×2^code cycles.
- R6: Write data bit 1 sets the ratio. A 0 makes `baud_en` fire once per 16 sampling enables, and a 1 makes it fire once per 64. Every `baud_en` pulse falls in a cycle with `sample_en` high.
- R7: Write data bit 0 drives `parity_odd`, where 1 means odd and 0 means even. It reads back in bit 0. Bit 1 reads back the ratio, and bits 5:3 read back the speed code.
- R8: With speed code 111, `sample_en` gives one single-cycle pulse per rising edge of `ext_clk`, after a two-flop synchroniser. The internal chain has no effect on it.
- R9: A write clears all divider counters. With prescale 0 and code 0, the first `sample_en` is seen 10 cycles after the write edge.
- R10: Write data bits 7:6 are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| ext_clk | input | 1 | External data clock (asynchronous) |
| cts_in | input | 1 | Clear-to-send pin; high means not clear |
| txbuf_empty | input | 1 | Real transmit buffer empty state |
| tx_empty | output | 1 | Transmit-empty flag gated by clear-to-send |
| parity_odd | output | 1 | Parity sense: 1 odd, 0 even |
| sample_en | output | 1 | Single-cycle sampling enable |
| baud_en | output | 1 | Single-cycle bit-rate enable |

## Verification
The bench measures the spacing between enable pulses for mixed prescale, speed and ratio settings. A design that swapped the 10 and 30 prescale, or that was off by one in a power-of-two mask, would give the wrong interval. It checks that the prescale bit reads back the pin and not the written value, since a design that stored the bit would echo the write. It checks the latency of the first pulse after a write, which a design that kept its counters running would miss. It checks that code 111 follows only external edges and stays quiet when the external clock stops, so a design that leaked the internal chain through would show stray pulses.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int CW = 6;
    localparam logic [2:0] CODE_EXT = 3'b111;

    typedef struct packed {
        logic [2:0] speed;
        logic       presc30;
        logic       ratio64;
        logic       par_odd;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{speed: 3'b111, presc30: 1'b0, ratio64: 1'b0, par_odd: 1'b0};
endpackage

// File: rtl/bcg_prescaler.sv
module bcg_prescaler #(
    parameter int LO = 10,
    parameter int HI = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sel_hi,
    output logic tick
);
    localparam int W = $clog2(HI);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] last;

    always_comb begin
        last  = sel_hi ? W'(HI - 1) : W'(LO - 1);
        tick  = !clr && (cnt_q == last);
        cnt_d = cnt_q + 1'b1;
        if (clr || tick || cnt_q > last) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the count never passes the top of the larger ratio
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(HI - 1));
endmodule

// File: rtl/bcg_pow2_div.sv
module bcg_pow2_div #(
    parameter int CW = 6,
    parameter int SW = $clog2(CW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_tick,
    input  logic [SW-1:0] shift,
    output logic          fire
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] mask;

    always_comb begin
        mask  = ~({CW{1'b1}} << shift);
        fire  = !clr && in_tick && ((cnt_q & mask) == mask);
        cnt_d = cnt_q;
        if (clr)          cnt_d = '0;
        else if (in_tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: a fire can only come from an input tick
    a_r5_fire_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> in_tick);
endmodule

// File: rtl/bcg_edge_sync.sv
module bcg_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], async_in};
        rise = sh_q[1] && !sh_q[2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R8: a rising edge lasts exactly one cycle
    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
    import baud_pkg::*;
#(
    parameter int PRE_LO = 10,
    parameter int PRE_HI = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       ext_clk,
    input  logic       cts_in,
    input  logic       txbuf_empty,
    output logic       tx_empty,
    output logic       parity_odd,
    output logic       sample_en,
    output logic       baud_en
);
    localparam int SW = $clog2(CW + 1);

    typedef struct packed {
        ctrl_t ctrl;
        logic  sample;
        logic  baud;
    } state_t;

    state_t        st_d, st_q;
    logic          pre_tick, spd_fire, ext_rise, sample_fire, baud_fire;
    logic [SW-1:0] spd_shift, rat_shift;

    bcg_prescaler #(.LO(PRE_LO), .HI(PRE_HI)) i_pre (
        .clk(clk), .rst_n(rst_n), .clr(wr_en),
        .sel_hi(st_q.ctrl.presc30), .tick(pre_tick)
    );

    bcg_pow2_div #(.CW(CW), .SW(SW)) i_speed (
        .clk(clk), .rst_n(rst_n), .clr(wr_en), .in_tick(pre_tick),
        .shift(spd_shift), .fire(spd_fire)
    );

    bcg_edge_sync i_ext (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise)
    );

    bcg_pow2_div #(.CW(CW), .SW(SW)) i_ratio (
        .clk(clk), .rst_n(rst_n), .clr(wr_en), .in_tick(sample_fire),
        .shift(rat_shift), .fire(baud_fire)
    );

    always_comb begin
        spd_shift   = SW'(st_q.ctrl.speed);
        rat_shift   = st_q.ctrl.ratio64 ? SW'(6) : SW'(4);
        sample_fire = (st_q.ctrl.speed == CODE_EXT) ? (ext_rise && !wr_en) : spd_fire;

        st_d        = st_q;
        st_d.sample = sample_fire;
        st_d.baud   = baud_fire;
        if (wr_en) begin
            st_d.ctrl = ctrl_t'(wr_data[5:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ctrl: CTRL_RST, sample: 1'b0, baud: 1'b0};
        else        st_q <= st_d;
    end

    assign rd_data    = {2'b00, st_q.ctrl.speed, cts_in, st_q.ctrl.ratio64, st_q.ctrl.par_odd};
    assign tx_empty   = txbuf_empty & ~cts_in;
    assign parity_odd = st_q.ctrl.par_odd;
    assign sample_en  = st_q.sample;
    assign baud_en    = st_q.baud;

    // R6: the bit-rate enable only comes with a sampling enable
    a_r6_baud_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        baud_en |-> sample_en);
    // R3: a high clear-to-send pin masks the empty flag
    a_r3_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cts_in |-> !tx_empty);
    // R2: prescale read position follows the pin
    a_r2_cts_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] == cts_in);
    // R7: the parity sense follows the written value
    a_r7_parity_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> parity_odd == $past(wr_data[0]));
    // R8: in external mode no sample pulse appears without an edge
    a_r8_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.speed == CODE_EXT && !ext_rise) |=> !sample_en);
    // R10: the upper read bits are always zero
    a_r10_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00);
endmodule

// File: tb/test_baud_clkgen.sv
module test_baud_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ext_clk = 1'b0;
    logic       cts_in = 1'b0;
    logic       txbuf_empty = 1'b0;
    logic       tx_empty, parity_odd, sample_en, baud_en;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  ext_run = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    baud_clkgen i_baud_clkgen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_clk(ext_clk), .cts_in(cts_in),
        .txbuf_empty(txbuf_empty), .tx_empty(tx_empty),
        .parity_odd(parity_odd), .sample_en(sample_en), .baud_en(baud_en)
    );

    // {prescale, ratio, code[2:0], sample period[15:0], baud period[15:0]}
    localparam int NV = 6;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd0, 16'd10,  16'd160},
        {1'b1, 1'b0, 3'd0, 16'd30,  16'd480},
        {1'b0, 1'b1, 3'd1, 16'd20,  16'd1280},
        {1'b0, 1'b0, 3'd3, 16'd80,  16'd1280},
        {1'b1, 1'b1, 3'd2, 16'd120, 16'd7680},
        {1'b0, 1'b0, 3'd6, 16'd640, 16'd10240}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // spacing between two successive pulses; -1 on timeout
    task automatic period(input bit use_baud, output int p);
        int t;
        p = -1;
        t = 0;
        while (t < 30000) begin
            @(negedge clk);
            t++;
            if (use_baud ? baud_en : sample_en) break;
        end
        if (t >= 30000) return;
        t = 0;
        while (t < 30000) begin
            @(negedge clk);
            t++;
            if (use_baud ? baud_en : sample_en) begin
                p = t;
                return;
            end
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (ext_run) begin
                repeat (3) @(negedge clk);
                ext_clk = ~ext_clk;
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<190000", cyc);
                summary();
            end
        end
    end

    initial begin
        int p, k, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_data", int'(rd_data), 8'b0011_1000);
        check("R1 parity_odd", int'(parity_odd), 0);
        check("R1 no sample pulse", int'(sample_en), 0);

        // R4 R5 R6 rate table
        for (int i = 0; i < NV; i++) begin
            wr({2'b00, VEC[i][34:32], VEC[i][36], VEC[i][35], 1'b0});
            period(1'b0, p);
            check($sformatf("R4/R5 sample period v%0d", i), p, int'(VEC[i][31:16]));
            period(1'b1, p);
            check($sformatf("R6 baud period v%0d", i), p, int'(VEC[i][15:0]));
        end

        // R6 count of sample pulses between baud pulses, ratio 64
        wr(8'b00_000_0_1_0);
        period(1'b1, p);
        cnt = 0;
        k = 0;
        while (k < 2000) begin
            @(negedge clk);
            k++;
            if (sample_en) cnt++;
            if (baud_en) break;
        end
        check("R6 samples per baud", cnt, 64);

        // R9 counters restart on write
        wr(8'b00_110_0_0_0);
        repeat (37) @(negedge clk);
        wr(8'b00_000_0_0_0);
        k = 0;
        while (k < 100) begin
            @(negedge clk);
            k++;
            if (sample_en) break;
        end
        check("R9 first pulse latency", k, 10);

        // R2 prescale read reflects pin
        wr(8'b00_000_1_0_0);
        cts_in = 1'b0;
        #1 check("R2 read bit2 cts low", int'(rd_data[2]), 0);
        cts_in = 1'b1;
        #1 check("R2 read bit2 cts high", int'(rd_data[2]), 1);
        period(1'b0, p);
        check("R4 rate kept by written prescale", p, 30);
        cts_in = 1'b0;

        // R3 empty gating
        txbuf_empty = 1'b1;
        #1 check("R3 empty passes", int'(tx_empty), 1);
        cts_in = 1'b1;
        #1 check("R3 empty masked", int'(tx_empty), 0);
        txbuf_empty = 1'b0;
        cts_in = 1'b0;
        #1 check("R3 not empty", int'(tx_empty), 0);

        // R7 parity sense and readback, R10 upper bits
        wr(8'b11_010_0_1_1);
        check("R7 parity odd", int'(parity_odd), 1);
        check("R7 R10 readback", int'(rd_data), 8'b00_010_0_1_1);
        wr(8'b00_010_0_1_0);
        check("R7 parity even", int'(parity_odd), 0);

        // R8 external clock: quiet first, then edges every 8 cycles
        wr(8'b00_111_0_0_0);
        cnt = 0;
        repeat (300) begin
            @(negedge clk);
            if (sample_en) cnt++;
        end
        check("R8 no pulses without edges", cnt, 0);
        ext_run = 1'b1;
        period(1'b0, p);
        check("R8 ext sample period", p, 8);
        period(1'b1, p);
        check("R8 ext baud period", p, 128);
        ext_run = 1'b0;

        done = 1'b1;
        summary();
    end
endmodule